// File: doc/BRIEF.md
# Scaled Readout Formatter

This block turns one raw 10-bit measurement into three printable ASCII digit characters for a character display. A request carries a field code that says which kind of reading the value is (oscillation rate, on-time share, or supply level) and the raw value itself. The block applies that field's fixed scaling with shifts and adds only. It then splits the scaled number into decimal digits by repeated subtraction of powers of ten. Finally it picks the three characters that the display shows for that field.

The caller pulses `start` with a field code and a value, waits for the one-cycle `done` pulse, and reads the three characters. `busy` marks the time while a request is being worked on. The character outputs are registered and hold their value between results, so a display refresher can fetch them at any time.

Top module: `readout_formatter`

## Requirements
- R1: Field code 0 (rate): the number is N = (((v + (v>>2))>>1) + v) >> 2, plus v, all shifted right by 3, plus 100, with no bits lost between steps. The number spans 100 at v=0 to 279 at v=1023. The outputs are N's hundreds, tens and units digits on char_hi, char_mid and char_lo.
- R2: Field code 1 (on-time share): the slice count s is bits 9..4 of v, and P = s + (s>>1). The outputs are the character '0', then P's tens digit, then P's units digit.
- R3: Field code 2 (supply level): M = 3*v. The outputs are the character '0', then M's thousands digit, then M's hundreds digit.
- R4: Every character is a decimal digit plus 0x30, so each output stays in the range 0x30 to 0x39.
- R5: A start with field code 3 is ignored. busy stays low, no done pulse follows, and the outputs keep their values.
- R6: After an accepted start, busy is high from the next cycle until the cycle in which done pulses. done lasts one cycle and is never high together with busy.
- R7: A start seen while busy is high is ignored. The result that follows belongs to the request that was accepted first.
- R8: The character outputs change only in a cycle where done is high. Otherwise they hold their last values, whatever the other inputs do.
- R9: Every accepted request finishes within 43 busy cycles.
- R10: After reset all three characters read 0x30, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, one cycle |
| field | input | 2 | 0 rate, 1 on-time share, 2 supply level, 3 unused |
| value | input | 10 | Raw reading |
| char_hi | output | 8 | Leftmost ASCII character |
| char_mid | output | 8 | Middle ASCII character |
| char_lo | output | 8 | Rightmost ASCII character |
| done | output | 1 | One-cycle pulse when the characters are updated |
| busy | output | 1 | High while a request is in progress |

## Verification
Directed requests cover the end points of each field: codes 0 and 1023 for all three fields, plus small on-time codes whose slice counts are odd and even. These show whether the half-value rounding and the carry-kept shift chain give exact values. Several hundred random requests across the three fields then cover every digit position, including the long subtraction runs that set the cycle bound. Some requests get a conflicting start part way through, and some are followed by idle input changes. Together these separate a correct result latch from one that takes late requests or leaks inputs to the outputs. A field-3 request checks that the unused code leaves busy, done and the characters unchanged.

// File: rtl/rdfmt_pkg.sv
package rdfmt_pkg;

  localparam int RAW_W     = 10;
  localparam int NUM_W     = 14;
  localparam int NDIG      = 5;
  localparam int RATE_BASE = 100;

  typedef enum logic [1:0] {
    FLD_RATE = 2'd0,
    FLD_DUTY = 2'd1,
    FLD_SUPP = 2'd2,
    FLD_NONE = 2'd3
  } field_e;

  function automatic int unsigned pow10(input int n);
    int unsigned r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  // Shift-add chain, about 0.1758 * code, then the base offset
  function automatic int unsigned rate_scale(input int unsigned code);
    int unsigned acc;
    acc = (code >> 2) + code;
    acc = (acc >> 1) + code;
    acc = (acc >> 2) + code;
    return (acc >> 3) + RATE_BASE;
  endfunction

  // Sixty-fourths to an approximate percentage
  function automatic int unsigned duty_scale(input int unsigned code);
    int unsigned slices;
    slices = code >> 4;
    return slices + (slices >> 1);
  endfunction

  function automatic int unsigned supp_scale(input int unsigned code);
    return (code << 1) + code;
  endfunction

  function automatic logic [7:0] to_ascii(input logic [3:0] d);
    return 8'h30 + {4'h0, d};
  endfunction

endpackage

// File: rtl/rdfmt_scaler.sv
module rdfmt_scaler
  import rdfmt_pkg::*;
#(
  parameter int RAW_W = rdfmt_pkg::RAW_W,
  parameter int NUM_W = rdfmt_pkg::NUM_W
) (
  input  field_e             fld,
  input  logic [RAW_W-1:0]   code,
  output logic [NUM_W-1:0]   num
);

  always_comb begin
    unique case (fld)
      FLD_RATE: num = NUM_W'(rate_scale(32'(code)));
      FLD_DUTY: num = NUM_W'(duty_scale(32'(code)));
      FLD_SUPP: num = NUM_W'(supp_scale(32'(code)));
      default:  num = '0;
    endcase
  end

endmodule

// File: rtl/rdfmt_bcd_seq.sv
module rdfmt_bcd_seq #(
  parameter int NUM_W = rdfmt_pkg::NUM_W,
  parameter int NDIG  = rdfmt_pkg::NDIG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NUM_W-1:0]      num,
  output logic [NDIG-1:0][3:0]  dig,
  output logic                  fin,
  output logic                  active
);

  localparam int IDX_W = $clog2(NDIG);
  localparam int LAST  = NDIG - 2;
  localparam int TAB_N = 1 << IDX_W;

  logic [NUM_W-1:0] wtab [TAB_N];
  logic [NUM_W-1:0] rem;
  logic [IDX_W-1:0] idx;
  logic [NUM_W-1:0] wgt;
  logic             take;
  logic             at_last;

  for (genvar g = 0; g < TAB_N; g++) begin : g_wtab
    if (g < NDIG - 1) begin : g_real
      assign wtab[g] = NUM_W'(rdfmt_pkg::pow10(NDIG - 1 - g));
    end else begin : g_pad
      assign wtab[g] = '1;
    end
  end

  assign wgt     = wtab[idx];
  assign take    = rem >= wgt;
  assign at_last = (idx == IDX_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem    <= '0;
      idx    <= '0;
      dig    <= '0;
      fin    <= 1'b0;
      active <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem    <= num;
        idx    <= '0;
        dig    <= '0;
        active <= 1'b1;
      end else if (active) begin
        if (take) begin
          rem      <= rem - wgt;
          dig[idx] <= dig[idx] + 4'd1;
        end else if (at_last) begin
          dig[NDIG-1] <= rem[3:0];
          active      <= 1'b0;
          fin         <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R4: a digit never counts past nine, the remainder for units is below ten
  p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && take) |-> (dig[idx] < 4'd9));
  p_units_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !take && at_last) |-> (rem < NUM_W'(10)));
  // R6: completion is announced only once the sequencer has gone idle
  p_fin_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !active);

endmodule

// File: rtl/rdfmt_char_pick.sv
module rdfmt_char_pick
  import rdfmt_pkg::*;
#(
  parameter int NDIG = rdfmt_pkg::NDIG
) (
  input  field_e               fld,
  input  logic [NDIG-1:0][3:0] dig,
  output logic [7:0]           c_hi,
  output logic [7:0]           c_mid,
  output logic [7:0]           c_lo
);

  // index 0 is the most significant digit
  localparam int P_UNIT = NDIG - 1;
  localparam int P_TEN  = NDIG - 2;
  localparam int P_HUN  = NDIG - 3;
  localparam int P_THO  = NDIG - 4;

  always_comb begin
    unique case (fld)
      FLD_RATE: begin
        c_hi  = to_ascii(dig[P_HUN]);
        c_mid = to_ascii(dig[P_TEN]);
        c_lo  = to_ascii(dig[P_UNIT]);
      end
      FLD_DUTY: begin
        c_hi  = to_ascii(4'd0);
        c_mid = to_ascii(dig[P_TEN]);
        c_lo  = to_ascii(dig[P_UNIT]);
      end
      FLD_SUPP: begin
        c_hi  = to_ascii(4'd0);
        c_mid = to_ascii(dig[P_THO]);
        c_lo  = to_ascii(dig[P_HUN]);
      end
      default: begin
        c_hi  = to_ascii(4'd0);
        c_mid = to_ascii(4'd0);
        c_lo  = to_ascii(4'd0);
      end
    endcase
  end

endmodule

// File: rtl/readout_formatter.sv
module readout_formatter
  import rdfmt_pkg::*;
#(
  parameter int RAW_W = rdfmt_pkg::RAW_W,
  parameter int NUM_W = rdfmt_pkg::NUM_W,
  parameter int NDIG  = rdfmt_pkg::NDIG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       field,
  input  logic [RAW_W-1:0] value,
  output logic [7:0]       char_hi,
  output logic [7:0]       char_mid,
  output logic [7:0]       char_lo,
  output logic             done,
  output logic             busy
);

  localparam int MAX_BUSY = (NDIG - 1) * 10 + 3;
  localparam int BCNT_W   = $clog2(MAX_BUSY + 2) + 1;

  field_e               fld_in;
  field_e               fld_q;
  logic                 req_take;
  logic [NUM_W-1:0]     scaled;
  logic [NDIG-1:0][3:0] digits;
  logic                 conv_fin;
  logic                 conv_active;
  logic [7:0]           pick_hi, pick_mid, pick_lo;
  logic [BCNT_W-1:0]    busy_cnt;

  assign fld_in   = field_e'(field);
  assign req_take = start && !busy && (fld_in != FLD_NONE);

  rdfmt_scaler #(.RAW_W(RAW_W), .NUM_W(NUM_W)) u_scale (
    .fld  (fld_in),
    .code (value),
    .num  (scaled)
  );

  rdfmt_bcd_seq #(.NUM_W(NUM_W), .NDIG(NDIG)) u_bcd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (req_take),
    .num    (scaled),
    .dig    (digits),
    .fin    (conv_fin),
    .active (conv_active)
  );

  rdfmt_char_pick #(.NDIG(NDIG)) u_pick (
    .fld   (fld_q),
    .dig   (digits),
    .c_hi  (pick_hi),
    .c_mid (pick_mid),
    .c_lo  (pick_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q    <= FLD_RATE;
      busy     <= 1'b0;
      done     <= 1'b0;
      char_hi  <= 8'h30;
      char_mid <= 8'h30;
      char_lo  <= 8'h30;
    end else begin
      done <= 1'b0;
      if (req_take) begin
        fld_q <= fld_in;
        busy  <= 1'b1;
      end else if (conv_fin) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        char_hi  <= pick_hi;
        char_mid <= pick_mid;
        char_lo  <= pick_lo;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> busy);
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fld_q));
  p_conv_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_active |-> busy);
  p_bad_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && fld_in == FLD_NONE) |=> !busy);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({char_hi, char_mid, char_lo}) |-> done);
  p_ascii_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_hi  inside {[8'h30:8'h39]}) &&
    (char_mid inside {[8'h30:8'h39]}) &&
    (char_lo  inside {[8'h30:8'h39]}));
  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BCNT_W'(MAX_BUSY));

endmodule

// File: tb/tb_readout_formatter.sv
`timescale 1ns/1ps
module tb_readout_formatter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] field = 2'd0;
  logic [9:0] value = 10'd0;
  logic [7:0] char_hi, char_mid, char_lo;
  logic       done, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  readout_formatter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .field(field), .value(value),
    .char_hi(char_hi), .char_mid(char_mid), .char_lo(char_lo),
    .done(done), .busy(busy)
  );

  function automatic logic [7:0] dch(input int n);
    return 8'(48 + (n % 10));
  endfunction

  function automatic logic [23:0] expect_chars(input int f, input int v);
    int n;
    case (f)
      0: begin
        n = v + v / 4;
        n = n / 2 + v;
        n = n / 4 + v;
        n = n / 8 + 100;
        return {dch(n / 100), dch(n / 10), dch(n)};
      end
      1: begin
        n = v / 16;
        n = n + n / 2;
        return {8'h30, dch(n / 10), dch(n)};
      end
      default: begin
        n = 3 * v;
        return {8'h30, dch(n / 1000), dch(n / 100)};
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int f);
    return (f == 0) ? "R1" : (f == 1) ? "R2" : "R3";
  endfunction

  task automatic do_req(input int f, input int v, input bit poke, input bit idle_after);
    int cyc;
    logic [23:0] held;
    @(negedge clk);
    start = 1'b1; field = 2'(f); value = 10'(v);
    @(negedge clk);
    start = 1'b0;
    check("R6 busy after start", {31'd0, busy}, 32'd1);
    cyc = 1;
    if (poke) begin
      // R7: conflicting request while busy
      start = 1'b1; field = 2'((f + 1) % 3); value = ~10'(v);
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check("R9 bounded latency", {31'd0, (cyc <= 45)}, 32'd1);
    check("R6 busy low with done", {31'd0, busy}, 32'd0);
    check(poke ? "R7 first request wins" : tag_of(f),
          {8'd0, char_hi, char_mid, char_lo}, {8'd0, expect_chars(f, v)});
    check("R4 ascii range", {31'd0, (char_lo >= 8'h30 && char_lo <= 8'h39)}, 32'd1);
    if (idle_after) begin
      // R8: inputs move without start; outputs must hold
      held = {char_hi, char_mid, char_lo};
      for (int i = 0; i < 4; i++) begin
        field = 2'(i); value = 10'($urandom);
        @(negedge clk);
        check("R8 no done while idle", {31'd0, done}, 32'd0);
      end
      check("R8 outputs held", {8'd0, char_hi, char_mid, char_lo}, {8'd0, held});
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    bit saw_done;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 chars after reset", {8'd0, char_hi, char_mid, char_lo}, 32'h00303030);
    check("R10 busy/done after reset", {30'd0, busy, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    do_req(0, 0, 0, 0);       // R1 lower end 100
    do_req(0, 1023, 0, 1);    // R1 upper end 279
    do_req(1, 0, 0, 0);       // R2 zero
    do_req(1, 1023, 0, 0);    // R2 63 slices -> 94
    do_req(1, 16, 0, 0);      // R2 one slice -> 1
    do_req(1, 47, 0, 0);      // R2 two slices, low bits ignored -> 3
    do_req(2, 0, 0, 0);       // R3 zero
    do_req(2, 1023, 0, 0);    // R3 3069
    do_req(2, 341, 1, 1);     // R3 1023 with R7 poke

    // R5: unused field code
    held = {char_hi, char_mid, char_lo};
    @(negedge clk);
    start = 1'b1; field = 2'd3; value = 10'd555;
    @(negedge clk);
    start = 1'b0;
    check("R5 busy stays low", {31'd0, busy}, 32'd0);
    saw_done = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) saw_done = 1'b1;
    end
    check("R5 no done", {31'd0, saw_done}, 32'd0);
    check("R5 outputs kept", {8'd0, char_hi, char_mid, char_lo}, {8'd0, held});

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      do_req(int'($urandom % 3), int'($urandom % 1024),
             ($urandom % 5) == 0, ($urandom % 7) == 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule